// File: doc/BRIEF.md
# Block Address Translator

This unit maps an effective address onto a real address through a small file of programmable large blocks. Each block is described by a register pair. The upper word holds the block's effective base, its size and two privilege-qualified valid bits. The lower word holds the real base and a 2-bit protection code. A lookup is purely combinational from the stored pairs. For each lookup the unit reports whether a block claimed the address, the translated address and whether the access is allowed. When no block claims the address, the caller sends it down a different translation path.

Software loads the pairs through a plain write port. When relocation is switched off, the address passes straight through and no check is made.

Top module: `bat_xlate`

## Requirements
- R1: A write with `wr_en_i` high stores `wr_data_i` into the word chosen by `wr_addr_i`, where bits [2:1] select the pair and bit 0 selects the upper word (0) or the lower word (1). Lookups see the new value from the cycle after the write edge. Reset clears every word, so no pair claims any address.
- R2: Upper-word bit 1 validates a pair in supervisor state (`user_i`=0), and bit 0 validates it in user state (`user_i`=1). A pair whose bit for the current state is clear never claims an address.
- R3: The size field is upper-word bits [12:2]. The offset mask is that field shifted left by 17, ORed with 0x1FFFF, so the smallest block is 128 KB. A field of 0x003 gives a 512 KB block.
- R4: A valid pair claims the address when (ea AND NOT mask) equals its upper word with bits [16:0] cleared.
- R5: On a claim, `ra_o` = (ea AND mask) OR (lower word with bits [16:0] cleared).
- R6: When several valid pairs claim the address, the lowest-numbered pair supplies the result.
- R7: The protection code is lower-word bits [1:0], and the access codes are 00 read, 01 write and 10 fetch. Code 00 faults every access. Code 10 allows every access. Codes 01 and 11 allow read and fetch and fault write.
- R8: With `relocate_i` low, `hit_o`=1, `fault_o`=0 and `ra_o`=`ea_i`, whatever the stored pairs hold.
- R9: `fault_o` is high only together with `hit_o`. With no claim, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 3 | {pair, lower-word select} |
| wr_data_i | input | 32 | register write data |
| relocate_i | input | 1 | translation enable |
| user_i | input | 1 | 1 = user state, 0 = supervisor |
| acc_i | input | 2 | access type: 00 read, 01 write, 10 fetch |
| ea_i | input | 32 | effective address |
| hit_o | output | 1 | address resolved by this unit |
| ra_o | output | 32 | real address (meaningless when fault_o) |
| fault_o | output | 1 | protection fault |

## Verification
Addresses are placed just inside and just outside the last byte of a minimum-size block and of a 512 KB block, which tells a correct mask width apart from one that is too wide or too narrow. Overlapping pairs are enabled and then disabled one at a time, which separates lowest-index priority from any other order. Pairs that are valid in only one privilege state are looked up from both states. Every protection code is crossed with every access type. Bypass lookups hit a pair coded 00, showing that the check is skipped when relocation is off.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int unsigned ACC_W = 2;
  typedef enum logic [ACC_W-1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10
  } acc_e;

  function automatic logic prot_allows(input logic [1:0] prot, input logic [ACC_W-1:0] acc);
    unique case (prot)
      2'b00:   prot_allows = 1'b0;
      2'b10:   prot_allows = 1'b1;
      default: prot_allows = (acc != ACC_WRITE);
    endcase
  endfunction
endpackage

// File: rtl/bat_regfile.sv
module bat_regfile #(
  parameter int unsigned AW     = 32,
  parameter int unsigned NPAIRS = 4,
  localparam int unsigned WA_W  = $clog2(NPAIRS) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [WA_W-1:0]      wr_addr_i,
  input  logic [AW-1:0]        wr_data_i,
  output logic [NPAIRS-1:0][AW-1:0] up_o,
  output logic [NPAIRS-1:0][AW-1:0] lo_o
);
  for (genvar i = 0; i < NPAIRS; i++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        up_o[i] <= '0;
        lo_o[i] <= '0;
      end else if (wr_en_i && wr_addr_i[WA_W-1:1] == (WA_W-1)'(i)) begin
        if (wr_addr_i[0]) lo_o[i] <= wr_data_i;
        else              up_o[i] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/bat_match.sv
module bat_match #(
  parameter int unsigned AW      = 32,
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned FLOOR_W = 17,
  parameter int unsigned LEN_LSB = 2
) (
  input  logic          user_i,
  input  logic [AW-1:0] ea_i,
  input  logic [AW-1:0] up_i,
  input  logic [AW-1:0] lo_i,
  output logic          hit_o,
  output logic [AW-1:0] ra_o
);
  localparam logic [AW-1:0] FLOOR_MASK = AW'({FLOOR_W{1'b1}});

  logic [LEN_W-1:0] len;
  logic [AW-1:0]    off_mask, base_ea, base_ra;
  logic             valid;

  assign len      = up_i[LEN_LSB +: LEN_W];
  assign off_mask = (AW'(len) << FLOOR_W) | FLOOR_MASK;
  assign base_ea  = up_i & ~FLOOR_MASK;
  assign base_ra  = lo_i & ~FLOOR_MASK;
  assign valid    = user_i ? up_i[0] : up_i[1];
  assign hit_o    = valid && ((ea_i & ~off_mask) == base_ea);
  assign ra_o     = (ea_i & off_mask) | base_ra;
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned NPAIRS  = 4,
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned FLOOR_W = 17,
  localparam int unsigned WA_W   = $clog2(NPAIRS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WA_W-1:0]  wr_addr_i,
  input  logic [AW-1:0]    wr_data_i,
  input  logic             relocate_i,
  input  logic             user_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [AW-1:0]    ea_i,
  output logic             hit_o,
  output logic [AW-1:0]    ra_o,
  output logic             fault_o
);
  logic [NPAIRS-1:0][AW-1:0] up, lo;
  logic [NPAIRS-1:0]         pair_hit;
  logic [NPAIRS-1:0][AW-1:0] pair_ra;
  logic                      any_hit;
  logic [AW-1:0]             win_ra;
  logic [1:0]                win_prot;

  bat_regfile #(.AW(AW), .NPAIRS(NPAIRS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .up_o(up), .lo_o(lo)
  );

  for (genvar i = 0; i < NPAIRS; i++) begin : g_match
    bat_match #(.AW(AW), .LEN_W(LEN_W), .FLOOR_W(FLOOR_W)) u_match (
      .user_i, .ea_i, .up_i(up[i]), .lo_i(lo[i]),
      .hit_o(pair_hit[i]), .ra_o(pair_ra[i])
    );
  end

  // descending scan: lowest index written last wins
  always_comb begin
    any_hit  = 1'b0;
    win_ra   = '0;
    win_prot = 2'b00;
    for (int i = NPAIRS - 1; i >= 0; i--) begin
      if (pair_hit[i]) begin
        any_hit  = 1'b1;
        win_ra   = pair_ra[i];
        win_prot = lo[i][1:0];
      end
    end
  end

  always_comb begin
    if (!relocate_i) begin
      hit_o   = 1'b1;
      ra_o    = ea_i;
      fault_o = 1'b0;
    end else begin
      hit_o   = any_hit;
      ra_o    = win_ra;
      fault_o = any_hit && !prot_allows(win_prot, acc_i);
    end
  end
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk
  import bat_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             relocate_i,
  input logic [ACC_W-1:0] acc_i,
  input logic [AW-1:0]    ea_i,
  input logic             hit_o,
  input logic [AW-1:0]    ra_o,
  input logic             fault_o,
  input logic [1:0]       win_prot
);
  p_fault_has_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> hit_o);
  p_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !relocate_i |-> (hit_o && !fault_o && ra_o == ea_i));
  p_code00_denies_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (relocate_i && hit_o && win_prot == 2'b00) |-> fault_o);
  p_code10_allows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (relocate_i && hit_o && win_prot == 2'b10) |-> !fault_o);
  p_write_needs_rw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (relocate_i && hit_o && !fault_o && acc_i == ACC_WRITE) |-> win_prot == 2'b10);
endmodule

bind bat_xlate bat_xlate_chk #(.AW(AW)) u_chk (.*);

// File: tb/bat_xlate_tb.sv
module bat_xlate_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        relocate_i = 1'b1;
  logic        user_i = 1'b0;
  logic [1:0]  acc_i = 2'b00;
  logic [31:0] ea_i = '0;
  logic        hit_o, fault_o;
  logic [31:0] ra_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] sh_up [4];
  logic [31:0] sh_lo [4];

  always #10 clk_i = ~clk_i;

  bat_xlate u_dut (.*);

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish (act=hung exp=done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [31:0] mk_up(logic [31:0] base, logic [10:0] len, logic sv, logic uv);
    return (base & 32'hFFFE_0000) | ({21'b0, len} << 2) | {30'b0, sv, uv};
  endfunction

  // reference model built from R2..R9
  function automatic logic [33:0] model(logic rel, logic usr, logic [1:0] acc, logic [31:0] ea);
    logic [31:0] m;
    if (!rel) return {1'b1, 1'b0, ea};
    for (int i = 0; i < 4; i++) begin
      m = ({21'b0, sh_up[i][12:2]} << 17) | 32'h1FFFF;
      if ((usr ? sh_up[i][0] : sh_up[i][1]) && ((ea & ~m) == (sh_up[i] & 32'hFFFE_0000))) begin
        logic ok;
        case (sh_lo[i][1:0])
          2'b00: ok = 1'b0;
          2'b10: ok = 1'b1;
          default: ok = (acc != 2'b01);
        endcase
        return {1'b1, !ok, (ea & m) | (sh_lo[i] & 32'hFFFE_0000)};
      end
    end
    return {1'b0, 1'b0, 32'h0};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (a[0]) sh_lo[a[2:1]] = d; else sh_up[a[2:1]] = d;
  endtask

  task automatic look(input string req, input logic rel, input logic usr,
                      input logic [1:0] acc, input logic [31:0] ea);
    logic [33:0] e;
    relocate_i = rel; user_i = usr; acc_i = acc; ea_i = ea;
    #2;
    e = model(rel, usr, acc, ea);
    checks++;
    if (hit_o !== e[33] || fault_o !== e[32] || (e[33] && !e[32] && ra_o !== e[31:0])) begin
      errors++;
      $display("FAIL %s ea=%h: act hit=%b fault=%b ra=%h exp hit=%b fault=%b ra=%h",
               req, ea, hit_o, fault_o, ra_o, e[33], e[32], e[31:0]);
    end
  endtask

  task automatic expect_ra(input string req, input logic [31:0] exp);
    checks++;
    if (hit_o !== 1'b1 || ra_o !== exp) begin
      errors++;
      $display("FAIL %s: act hit=%b ra=%h exp hit=1 ra=%h", req, hit_o, ra_o, exp);
    end
  endtask

  task automatic t_reset;
    look("R1", 1'b1, 1'b0, 2'b00, 32'h0000_0000);
    look("R1", 1'b1, 1'b1, 2'b00, 32'h1000_0000);
  endtask

  task automatic t_write_timing;
    wr(3'b001, 32'h8000_0002);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'b000; wr_data_i = mk_up(32'h1000_0000, 11'h0, 1'b1, 1'b1);
    look("R1", 1'b1, 1'b0, 2'b00, 32'h1000_0040); // before edge: still miss
    @(negedge clk_i);
    wr_en_i = 1'b0;
    sh_up[0] = mk_up(32'h1000_0000, 11'h0, 1'b1, 1'b1);
    look("R1", 1'b1, 1'b0, 2'b00, 32'h1000_0040);
    expect_ra("R1", 32'h8000_0040);
  endtask

  task automatic t_basic;
    look("R4", 1'b1, 1'b0, 2'b00, 32'h1001_FFFC);
    expect_ra("R5", 32'h8001_FFFC);
    look("R3", 1'b1, 1'b0, 2'b00, 32'h1002_0000);
    look("R4", 1'b1, 1'b0, 2'b10, 32'h0FFF_FFFC);
  endtask

  task automatic t_size;
    wr(3'b011, 32'h4000_0002);
    wr(3'b010, mk_up(32'h2000_0000, 11'h003, 1'b1, 1'b1));
    look("R3", 1'b1, 1'b0, 2'b00, 32'h2007_FFFC);
    expect_ra("R3", 32'h4007_FFFC);
    look("R3", 1'b1, 1'b0, 2'b00, 32'h2008_0000);
    look("R3", 1'b1, 1'b1, 2'b10, 32'h2004_0010);
  endtask

  task automatic t_priv;
    wr(3'b101, 32'h5000_0002);
    wr(3'b100, mk_up(32'h3000_0000, 11'h0, 1'b1, 1'b0));
    look("R2", 1'b1, 1'b0, 2'b00, 32'h3000_0100);
    look("R2", 1'b1, 1'b1, 2'b00, 32'h3000_0100);
    wr(3'b111, 32'h6000_0002);
    wr(3'b110, mk_up(32'h3000_0000, 11'h0, 1'b0, 1'b1));
    look("R2", 1'b1, 1'b1, 2'b00, 32'h3000_0100);
    expect_ra("R2", 32'h6000_0100);
    look("R2", 1'b1, 1'b0, 2'b00, 32'h3000_0100);
    expect_ra("R2", 32'h5000_0100);
  endtask

  task automatic t_prio;
    wr(3'b110, mk_up(32'h1000_0000, 11'h0, 1'b1, 1'b1));
    wr(3'b111, 32'h9000_0002);
    look("R6", 1'b1, 1'b0, 2'b00, 32'h1000_0010);
    expect_ra("R6", 32'h8000_0010);
    wr(3'b000, mk_up(32'h1000_0000, 11'h0, 1'b0, 1'b0));
    look("R6", 1'b1, 1'b0, 2'b00, 32'h1000_0010);
    expect_ra("R6", 32'h9000_0010);
    wr(3'b010, mk_up(32'h1000_0000, 11'h001, 1'b1, 1'b1));
    look("R6", 1'b1, 1'b0, 2'b00, 32'h1000_0010);
    expect_ra("R6", 32'h4000_0010);
  endtask

  task automatic t_prot;
    for (int p = 0; p < 4; p++) begin
      wr(3'b011, 32'h4000_0000 | p);
      for (int a = 0; a < 3; a++) begin
        look("R7", 1'b1, 1'b0, 2'(a), 32'h1000_0020);
        checks++;
        if (fault_o && !hit_o) begin
          errors++;
          $display("FAIL R9: act fault=1 hit=0 exp hit=1");
        end
      end
    end
    look("R9", 1'b1, 1'b0, 2'b01, 32'h7000_0000);
  endtask

  task automatic t_bypass;
    wr(3'b011, 32'h4000_0000);
    look("R8", 1'b0, 1'b0, 2'b01, 32'h1000_0020);
    look("R8", 1'b0, 1'b1, 2'b10, 32'hDEAD_BEEC);
    look("R8", 1'b1, 1'b0, 2'b01, 32'h1000_0020);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin sh_up[i] = '0; sh_lo[i] = '0; end
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_write_timing();
    t_basic();
    t_size();
    t_priv();
    t_prio();
    t_prot();
    t_bypass();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule